// File: doc/BRIEF.md
# DMA channel suspend and abort controller

This block is the control and buffering path of a single DMA channel that reads narrow source beats and writes wider destination words. Source bytes go into a small circular buffer, and the channel packs them into destination words with the earliest byte in the lowest lane. Each bus side is a request/response handshake. A response is either accepted (OKAY) or refused with a retry. After a retry the channel presents the same beat again until that beat is accepted.

Software starts the channel with a one-cycle enable pulse and a beat count. It can stop the channel in two ways:

- **Orderly stop.** Software raises the suspend level, which stops new source reads while destination writes keep draining the buffer. When the empty flag reports that no further destination write can be formed, software requests a disable.
- **Abrupt stop.** Software pulses the clear input or drops the global enable. Either one is only a request. The enable status stays high until every outstanding handshake, retried ones included, has been accepted. Any bytes still buffered at that point are dropped.

Top module: `dma_chan_ctrl`

## Requirements
- R1: A one-cycle `en_set` pulse starts a transfer of `xfer_len` source beats, but only while the channel is off, `glb_en` is high and `en_clr` is low. `ch_en` then reads 1. It returns to 0 by itself on the second rising edge after the last destination write is accepted.
- R2: No new source request starts while `susp` is high, although an outstanding one still completes. Destination writes continue while suspended, so every complete 4-byte word held in the buffer is written.
- R3: Byte k of a transfer, counting from 0, appears in lane k mod 4 (bits 8*(k mod 4)+7 down to 8*(k mod 4)) of destination write k/4. Every full word carries `dst_strb` = 4'b1111. A final word with n = 1..3 bytes carries the n low strobe bits, i.e. 2^n-1.
- R4: `fifo_empty` is 1 when no destination write is outstanding and the buffer holds neither a full word nor exactly the last bytes of the transfer. Up to 3 bytes may remain buffered while it reads 1.
- R5: When `susp` returns low, source reads resume and the transfer completes with every beat written in order.
- R6: A disable request is a pulse on `en_clr` while `ch_en` is 1. After it, no new request starts on either side, and `ch_en` stays 1 while any handshake is outstanding. `ch_en` falls on the second rising edge after the last outstanding handshake is accepted, or on the edge that samples the request if nothing is outstanding.
- R7: When a request receives a retry (`*_rsp_valid`=1 with `*_rsp_retry`=1), the request stays high on the next cycle. On the source side `src_idx` stays unchanged. On the destination side `dst_wdata` and `dst_strb` stay unchanged.
- R8: While `ch_en` is 1, `glb_en` low acts as a disable request with the timing of R6. An `en_set` pulse while `glb_en` is low is ignored, and `ch_en` stays 0.
- R9: Bytes still buffered when the channel turns off are never written. Re-enabling empties the buffer, so the first write of the new transfer carries that transfer's first bytes.
- R10: During a request, `src_idx` equals the number of source beats accepted so far in the current transfer, starting from 0 at each enable.
- R11: After reset, `ch_en`, `src_req` and `dst_req` are 0 and `fifo_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable; low requests a disable |
| en_set | input | 1 | Enable pulse that starts a transfer |
| en_clr | input | 1 | Disable-request pulse |
| susp | input | 1 | Suspend level; blocks new source reads |
| xfer_len | input | 12 | Transfer length in source beats, captured at start |
| ch_en | output | 1 | Channel enable status |
| fifo_empty | output | 1 | No destination write can be formed or is outstanding |
| src_req | output | 1 | Source read request |
| src_idx | output | 12 | Beat index of the current source request |
| src_rsp_valid | input | 1 | Source response present |
| src_rsp_retry | input | 1 | Source response is a retry |
| src_rdata | input | 8 | Source read byte |
| dst_req | output | 1 | Destination write request |
| dst_wdata | output | 32 | Packed destination word |
| dst_strb | output | 4 | Destination byte strobes |
| dst_rsp_valid | input | 1 | Destination response present |
| dst_rsp_retry | input | 1 | Destination response is a retry |

## Verification
Uninterrupted transfers are swept over every length from 1 to 13 beats and over three source response latencies. This sweep covers each final-word strobe pattern, and it separates correct lane order and strobe masks from off-by-one packing errors. Retries on the first beat of each side show whether a refused beat is reissued unchanged, with the same data and the same index.

A suspend placed after exactly five, and in a second case seven, accepted beats leaves one and three bytes stranded. These cases test that the empty flag ignores stranded bytes and that resuming finishes cleanly. A disable issued against stranded bytes, followed by a fresh transfer, shows whether the stale bytes leak into the new data.

A destination held in continuous retry during an abort separates deferred disabling from immediate disabling, and it measures the exact stop latency once the retry clears. Dropping the global enable in mid-transfer tests the second stop path.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    // Channel control states
    typedef enum logic [1:0] {
        CH_OFF      = 2'd0,
        CH_ACTIVE   = 2'd1,
        CH_STOPPING = 2'd2
    } ch_state_e;

    localparam int MAX_LANES = 16;

    // Mask with the n lowest lanes set
    function automatic logic [MAX_LANES-1:0] low_lanes(input int unsigned n);
        logic [MAX_LANES-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < MAX_LANES; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dcc_hs_port.sv
// One outstanding request/response handshake; payload held across retries.
module dcc_hs_port #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic [PW-1:0] pay_in,
    input  logic          rsp_valid,
    input  logic          rsp_retry,
    output logic          req,
    output logic [PW-1:0] pay,
    output logic          okay
);
    assign okay = req && rsp_valid && !rsp_retry;

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
            pay <= '0;
        end else if (okay) begin
            req <= 1'b0;
        end else if (!req && issue) begin
            req <= 1'b1;
            pay <= pay_in;
        end
    end
endmodule

// File: rtl/dcc_byte_fifo.sv
// Circular byte buffer: one push per cycle, pop of up to LANES bytes, word peek.
module dcc_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int LANES = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int NB_W  = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               push,
    input  logic [W-1:0]       push_data,
    input  logic [NB_W-1:0]    pop_n,
    output logic [CNT_W-1:0]   count,
    output logic [LANES*W-1:0] peek
);
    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            rp_q  <= rp_q + PTR_W'(pop_n);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[wp_q] <= push_data;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [PTR_W-1:0] idx;
        assign idx = rp_q + PTR_W'(i);
        assign peek[i*W +: W] = mem_q[idx];
    end

    assign count = cnt_q;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dcc_pkg::*;
#(
    parameter int SRC_W      = 8,
    parameter int DST_W      = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int LEN_W      = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   glb_en,
    input  logic                   en_set,
    input  logic                   en_clr,
    input  logic                   susp,
    input  logic [LEN_W-1:0]       xfer_len,
    output logic                   ch_en,
    output logic                   fifo_empty,
    output logic                   src_req,
    output logic [LEN_W-1:0]       src_idx,
    input  logic                   src_rsp_valid,
    input  logic                   src_rsp_retry,
    input  logic [SRC_W-1:0]       src_rdata,
    output logic                   dst_req,
    output logic [DST_W-1:0]       dst_wdata,
    output logic [DST_W/SRC_W-1:0] dst_strb,
    input  logic                   dst_rsp_valid,
    input  logic                   dst_rsp_retry
);
    localparam int BPW   = DST_W / SRC_W;
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int NB_W  = $clog2(BPW + 1);

    typedef struct packed {
        logic [NB_W-1:0]  nb;
        logic [BPW-1:0]   strb;
        logic [DST_W-1:0] data;
    } dst_beat_t;

    ch_state_e        st_q;
    logic [LEN_W-1:0] len_q, rd_cnt_q, wr_cnt_q, remaining;
    logic [CNT_W-1:0] fcnt;
    logic [DST_W-1:0] peek;
    logic [NB_W-1:0]  word_n, pop_n;
    logic             dis_now, start, ports_idle, done_now, stop_now, flush;
    logic             src_issue, src_ok, dst_can, dst_issue, dst_ok;
    dst_beat_t        beat_in, dst_pay;

    // Control decisions
    assign dis_now    = en_clr || !glb_en;
    assign start      = (st_q == CH_OFF) && en_set && !en_clr && glb_en;
    assign ports_idle = !src_req && !dst_req;
    assign remaining  = len_q - wr_cnt_q;
    assign done_now   = (st_q == CH_ACTIVE) && !dis_now && ports_idle && (wr_cnt_q == len_q);
    assign stop_now   = ports_idle &&
                        (((st_q == CH_ACTIVE) && dis_now) || (st_q == CH_STOPPING));
    assign flush      = start || stop_now;

    // Source side: one beat at a time while space remains
    assign src_issue = (st_q == CH_ACTIVE) && !dis_now && !susp &&
                       (rd_cnt_q < len_q) && (fcnt < CNT_W'(FIFO_DEPTH));

    // Destination side: full word, or exactly the tail of the transfer
    assign dst_can   = (fcnt >= CNT_W'(BPW)) ||
                       ((fcnt != '0) && (LEN_W'(fcnt) == remaining));
    assign dst_issue = (st_q == CH_ACTIVE) && !dis_now && dst_can;
    assign word_n    = (fcnt >= CNT_W'(BPW)) ? NB_W'(BPW) : NB_W'(fcnt);

    always_comb begin
        logic [BPW-1:0] strb;
        strb         = BPW'(low_lanes(32'(word_n)));
        beat_in.nb   = word_n;
        beat_in.strb = strb;
        for (int i = 0; i < BPW; i++) begin
            beat_in.data[i*SRC_W +: SRC_W] = strb[i] ? peek[i*SRC_W +: SRC_W] : '0;
        end
    end

    assign pop_n = dst_ok ? dst_pay.nb : '0;

    dcc_byte_fifo #(
        .W     (SRC_W),
        .DEPTH (FIFO_DEPTH),
        .LANES (BPW)
    ) fifo_i (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (src_ok),
        .push_data (src_rdata),
        .pop_n     (pop_n),
        .count     (fcnt),
        .peek      (peek)
    );

    dcc_hs_port #(.PW(LEN_W)) src_port_i (
        .clk       (clk),
        .rst       (rst),
        .issue     (src_issue),
        .pay_in    (rd_cnt_q),
        .rsp_valid (src_rsp_valid),
        .rsp_retry (src_rsp_retry),
        .req       (src_req),
        .pay       (src_idx),
        .okay      (src_ok)
    );

    dcc_hs_port #(.PW($bits(dst_beat_t))) dst_port_i (
        .clk       (clk),
        .rst       (rst),
        .issue     (dst_issue),
        .pay_in    (beat_in),
        .rsp_valid (dst_rsp_valid),
        .rsp_retry (dst_rsp_retry),
        .req       (dst_req),
        .pay       (dst_pay),
        .okay      (dst_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= CH_OFF;
            len_q    <= '0;
            rd_cnt_q <= '0;
            wr_cnt_q <= '0;
        end else begin
            if (src_ok) rd_cnt_q <= rd_cnt_q + 1'b1;
            if (dst_ok) wr_cnt_q <= wr_cnt_q + LEN_W'(dst_pay.nb);
            unique case (st_q)
                CH_OFF: begin
                    if (start) begin
                        st_q     <= CH_ACTIVE;
                        len_q    <= xfer_len;
                        rd_cnt_q <= '0;
                        wr_cnt_q <= '0;
                    end
                end
                CH_ACTIVE: begin
                    if (dis_now)       st_q <= ports_idle ? CH_OFF : CH_STOPPING;
                    else if (done_now) st_q <= CH_OFF;
                end
                CH_STOPPING: begin
                    if (ports_idle) st_q <= CH_OFF;
                end
                default: st_q <= CH_OFF;
            endcase
        end
    end

    assign ch_en      = (st_q != CH_OFF);
    assign fifo_empty = !dst_req && !dst_can;
    assign dst_wdata  = dst_pay.data;
    assign dst_strb   = dst_pay.strb;
endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
    parameter int LEN_W = 12,
    parameter int DST_W = 32,
    parameter int BPW   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             glb_en,
    input logic             en_clr,
    input logic             susp,
    input logic             ch_en,
    input logic             src_req,
    input logic [LEN_W-1:0] src_idx,
    input logic             src_rsp_valid,
    input logic             src_rsp_retry,
    input logic             dst_req,
    input logic [DST_W-1:0] dst_wdata,
    input logic [BPW-1:0]   dst_strb,
    input logic             dst_rsp_valid,
    input logic             dst_rsp_retry
);
    AST_SRC_RETRY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (src_req && src_rsp_valid && src_rsp_retry) |=> (src_req && $stable(src_idx))); // R7

    AST_DST_RETRY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dst_req && dst_rsp_valid && dst_rsp_retry)
            |=> (dst_req && $stable(dst_wdata) && $stable(dst_strb))); // R7

    AST_SUSP_NO_SRC: assert property (@(posedge clk) disable iff (rst)
        (!src_req && susp) |=> !src_req); // R2

    AST_EN_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ch_en && (src_req || dst_req)) |=> ch_en); // R6

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ch_en |-> (!src_req && !dst_req)); // R6

    AST_NO_ISSUE_AFTER_CLR: assert property (@(posedge clk) disable iff (rst)
        (ch_en && !src_req && (en_clr || !glb_en)) |=> !src_req); // R8

    AST_STRB_CONTIG: assert property (@(posedge clk) disable iff (rst)
        dst_req |-> (dst_strb[0] && $onehot0({1'b0, dst_strb} + 1'b1))); // R3
endmodule

bind dma_chan_ctrl dcc_chk #(
    .LEN_W (LEN_W),
    .DST_W (DST_W),
    .BPW   (DST_W / SRC_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .glb_en        (glb_en),
    .en_clr        (en_clr),
    .susp          (susp),
    .ch_en         (ch_en),
    .src_req       (src_req),
    .src_idx       (src_idx),
    .src_rsp_valid (src_rsp_valid),
    .src_rsp_retry (src_rsp_retry),
    .dst_req       (dst_req),
    .dst_wdata     (dst_wdata),
    .dst_strb      (dst_strb),
    .dst_rsp_valid (dst_rsp_valid),
    .dst_rsp_retry (dst_rsp_retry)
);

// File: tb/dma_chan_ctrl_tb_top.sv
module dma_chan_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        glb_en = 1'b1, en_set = 1'b0, en_clr = 1'b0, susp = 1'b0;
    logic [11:0] xfer_len = '0;
    logic        ch_en, fifo_empty, src_req, dst_req;
    logic [11:0] src_idx;
    logic        src_rsp_valid = 1'b0, src_rsp_retry = 1'b0;
    logic [7:0]  src_rdata = '0;
    logic [31:0] dst_wdata;
    logic [3:0]  dst_strb;
    logic        dst_rsp_valid = 1'b0, dst_rsp_retry = 1'b0;

    always #10 clk = ~clk;

    dma_chan_ctrl dut_i (
        .clk(clk), .rst(rst), .glb_en(glb_en), .en_set(en_set), .en_clr(en_clr),
        .susp(susp), .xfer_len(xfer_len), .ch_en(ch_en), .fifo_empty(fifo_empty),
        .src_req(src_req), .src_idx(src_idx), .src_rsp_valid(src_rsp_valid),
        .src_rsp_retry(src_rsp_retry), .src_rdata(src_rdata), .dst_req(dst_req),
        .dst_wdata(dst_wdata), .dst_strb(dst_strb), .dst_rsp_valid(dst_rsp_valid),
        .dst_rsp_retry(dst_rsp_retry)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Responder state and scoreboard
    int       src_delay = 0, src_wait = 0, src_retry_left = 0, dst_retry_left = 0;
    bit       dst_hold = 0;
    logic [7:0] seed = '0;
    int       ok_cnt = 0, wr_bytes = 0, writes = 0, last_ok_cyc = 0;
    int       data_err = 0, addr_err = 0, hold_err = 0, strb_err = 0;
    logic [3:0]  last_strb = '0;
    bit          src_rt = 0, dst_rt = 0;
    logic [11:0] rt_idx = '0;
    logic [31:0] rt_data = '0;
    logic [3:0]  rt_strb = '0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bus responders: drive on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            src_rsp_valid = 1'b0; src_rsp_retry = 1'b0;
            dst_rsp_valid = 1'b0; dst_rsp_retry = 1'b0;
            if (src_req) begin
                if (src_wait < src_delay) begin
                    src_wait++;
                end else begin
                    src_wait = 0;
                    src_rsp_valid = 1'b1;
                    if (src_rt && src_idx != rt_idx) hold_err++;
                    if (src_retry_left > 0) begin
                        src_retry_left--;
                        src_rsp_retry = 1'b1;
                        src_rt = 1; rt_idx = src_idx;
                    end else begin
                        src_rt = 0;
                        if (src_idx != 12'(ok_cnt)) addr_err++;
                        src_rdata = seed + 8'(ok_cnt);
                        ok_cnt++;
                    end
                end
            end
            if (dst_req) begin
                dst_rsp_valid = 1'b1;
                if (dst_rt && (dst_wdata != rt_data || dst_strb != rt_strb)) hold_err++;
                if (dst_hold || dst_retry_left > 0) begin
                    if (dst_retry_left > 0) dst_retry_left--;
                    dst_rsp_retry = 1'b1;
                    dst_rt = 1; rt_data = dst_wdata; rt_strb = dst_strb;
                end else begin
                    int n;
                    dst_rt = 0;
                    n = 0;
                    for (int l = 0; l < 4; l++) if (dst_strb[l]) n++;
                    if (dst_strb != 4'((1 << n) - 1)) strb_err++;
                    for (int l = 0; l < n; l++) begin
                        if (dst_wdata[l*8 +: 8] != seed + 8'(wr_bytes)) data_err++;
                        wr_bytes++;
                    end
                    writes++;
                    last_strb = dst_strb;
                    last_ok_cyc = cyc;
                end
            end
        end
    end

    task automatic start_xfer(input int len, input logic [7:0] sd);
        @(negedge clk);
        seed = sd; ok_cnt = 0; wr_bytes = 0; writes = 0;
        data_err = 0; addr_err = 0; hold_err = 0; strb_err = 0;
        src_rt = 0; dst_rt = 0; src_wait = 0;
        xfer_len = 12'(len);
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); en_clr = 1'b1;
        @(negedge clk); en_clr = 1'b0;
    endtask

    task automatic wait_off(input int maxc, output int offc);
        offc = -1;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (!ch_en) begin offc = cyc; break; end
        end
    endtask

    task automatic run_plain(input int len, input int d);
        int offc, expw;
        logic [3:0] exps;
        src_delay = d;
        src_retry_left = len % 3;
        dst_retry_left = (len + d) % 2;
        start_xfer(len, 8'(len * 16 + d));
        wait_off(400, offc);
        expw = (len + 3) / 4;
        exps = (len % 4 == 0) ? 4'hF : 4'((1 << (len % 4)) - 1);
        chk(offc >= 0, "R1 channel self-clears", offc, 0);
        chk(offc - last_ok_cyc == 2, "R1 off latency", offc - last_ok_cyc, 2);
        chk(wr_bytes == len, "R3 bytes written", wr_bytes, len);
        chk(writes == expw, "R3 write count", writes, expw);
        chk(last_strb == exps, "R3 final strobes", last_strb, exps);
        chk(data_err == 0 && strb_err == 0, "R3 lane order", data_err + strb_err, 0);
        chk(addr_err == 0, "R10 beat index", addr_err, 0);
        chk(hold_err == 0, "R7 retry hold", hold_err, 0);
    endtask

    initial begin
        int offc, a, b, okc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!ch_en, "R11 ch_en", ch_en, 0);
        chk(!src_req && !dst_req, "R11 requests", {src_req, dst_req}, 0);
        chk(fifo_empty, "R11 fifo_empty", fifo_empty, 1);

        // R1 R3 R7 R10: length and latency sweep with retries
        for (int len = 1; len <= 13; len++)
            for (int d = 0; d < 3; d++)
                run_plain(len, d);

        // R2 R4 R5: suspend after 5 beats, leaving 1 byte stranded
        src_delay = 0; src_retry_left = 0; dst_retry_left = 0;
        start_xfer(22, 8'h40);
        do @(posedge clk); while (ok_cnt < 5);
        @(negedge clk); susp = 1'b1;
        repeat (20) @(posedge clk);
        a = ok_cnt;
        repeat (20) @(posedge clk);
        b = ok_cnt;
        chk(a == 5 && b == a, "R2 no source reads while suspended", b, 5);
        chk(wr_bytes == 4, "R2 full word drained", wr_bytes, 4);
        @(negedge clk);
        chk(!src_req, "R2 source idle", src_req, 0);
        chk(fifo_empty, "R4 empty with 1 stranded byte", fifo_empty, 1);
        chk(ch_en, "R5 still enabled while suspended", ch_en, 1);
        susp = 1'b0;
        wait_off(200, offc);
        chk(offc >= 0 && wr_bytes == 22, "R5 resume completes", wr_bytes, 22);
        chk(writes == 6 && last_strb == 4'b0011, "R5 tail strobes", last_strb, 3);
        chk(data_err == 0, "R5 data in order", data_err, 0);

        // R9 R10: stranded 3 bytes discarded, then fresh transfer
        start_xfer(22, 8'h80);
        do @(posedge clk); while (ok_cnt < 7);
        @(negedge clk); susp = 1'b1;
        repeat (20) @(negedge clk);
        chk(ok_cnt == 7 && wr_bytes == 4, "R4 three bytes stranded", ok_cnt - wr_bytes, 3);
        chk(fifo_empty, "R4 empty with 3 stranded bytes", fifo_empty, 1);
        pulse_clr();
        wait_off(20, offc);
        chk(offc >= 0, "R6 idle disable", offc, 0);
        susp = 1'b0;
        repeat (5) @(negedge clk);
        chk(wr_bytes == 4, "R9 stranded bytes never written", wr_bytes, 4);
        start_xfer(4, 8'hC0);
        wait_off(100, offc);
        chk(writes == 1 && wr_bytes == 4, "R9 single fresh word", wr_bytes, 4);
        chk(data_err == 0, "R9 no stale bytes", data_err, 0);
        chk(addr_err == 0, "R10 index restarts", addr_err, 0);

        // R6 R7: abort while the destination keeps retrying
        src_delay = 3; dst_hold = 1;
        start_xfer(16, 8'h20);
        do @(negedge clk); while (!dst_req);
        en_clr = 1'b1;
        @(posedge clk); okc = ok_cnt;
        @(negedge clk); en_clr = 1'b0;
        repeat (12) @(negedge clk);
        chk(ch_en, "R6 held while retry outstanding", ch_en, 1);
        chk(dst_req, "R7 request kept", dst_req, 1);
        chk(!fifo_empty, "R4 not empty with write outstanding", fifo_empty, 0);
        chk(ok_cnt - okc <= 1, "R6 no new source beats", ok_cnt - okc, 1);
        @(posedge clk); dst_hold = 0;
        wait_off(20, offc);
        chk(offc >= 0 && offc - last_ok_cyc == 2, "R6 stop latency", offc - last_ok_cyc, 2);
        chk(wr_bytes == 4 && hold_err == 0, "R7 retried word written once", wr_bytes, 4);
        chk(fifo_empty, "R9 buffer dropped", fifo_empty, 1);

        // R8: global enable
        src_delay = 0;
        start_xfer(40, 8'h10);
        repeat (10) @(negedge clk);
        glb_en = 1'b0;
        wait_off(20, offc);
        chk(offc >= 0, "R8 global disable", offc, 0);
        @(negedge clk); en_set = 1'b1;
        @(negedge clk); en_set = 1'b0;
        repeat (3) @(negedge clk);
        chk(!ch_en && !src_req, "R8 start ignored", ch_en, 0);
        glb_en = 1'b1;
        run_plain(5, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule